// File: doc/BRIEF.md
# Token Channel End Buffer

This block is one end of a full-duplex message channel that carries 9-bit tokens. A token is either a data token or a control token, and its low 8 bits hold the value. The block has two token queues. The outbound queue is filled by a thread-side request port and drained one token at a time onto a valid/ready link output. The inbound queue is filled one token at a time from a valid/ready link input and drained by the thread-side request port.

The thread side issues four kinds of request. Output-word splits a 32-bit word into four data tokens. Output-token sends one data or control token. Input-word gathers four data tokens into a word. Input-token returns one token together with its control flag. A request completes in the cycle it can be served in full. Until then the block raises `stall`, and the requester must hold the request unchanged. Control tokens can be mixed in with data, so higher-level protocols can be built on the channel. An input-word that would run into a control token is refused instead of being served.

Top module: `chan_end`

## Requirements
- R1: After reset `stall`, `proto_err` and `tx_valid` are low, `rx_ready` is high, and both queues are empty.
- R2: An output-word request (`req_op` = 0) puts four data tokens (bit 8 clear) into the outbound queue in one cycle. The tokens leave on `tx_token` most significant byte first.
- R3: An output-token request (`req_op` = 1) puts one token into the outbound queue. Its bit 8 is `req_ctrl` and its bits [7:0] are `req_wdata[7:0]`.
- R4: An output request whose tokens do not all fit in the free space of the 8-entry outbound queue holds `stall` high in every cycle and writes nothing. It completes, writing all of its tokens at once, in the first cycle after enough space has been freed.
- R5: An input-word request (`req_op` = 2) stalls while fewer than four tokens are buffered. Once four data tokens are present it completes, returns them on `rsp_data` with the oldest token in bits [31:24], and removes all four.
- R6: An input-token request (`req_op` = 3) stalls while the inbound queue is empty. Otherwise it returns the oldest token's value on `rsp_data[7:0]` and its bit 8 on `rsp_ctrl`, and removes that token.
- R7: An input-word request with at least four tokens buffered, one or more of which among the oldest four is a control token, raises `proto_err` for that cycle, does not stall, and removes no token.
- R8: `rx_ready` is low while the inbound queue holds 8 tokens. A token offered at that time is not stored.
- R9: The outbound and inbound link transfers can both complete in the same cycle.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_token` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Thread request present |
| req_op | input | 2 | 0 output-word, 1 output-token, 2 input-word, 3 input-token |
| req_wdata | input | 32 | Word or token value to send |
| req_ctrl | input | 1 | Control flag for output-token |
| stall | output | 1 | Request cannot complete this cycle |
| proto_err | output | 1 | Input-word refused because a control token is in the way |
| rsp_data | output | 32 | Input result, valid in the completing cycle |
| rsp_ctrl | output | 1 | Control flag of the token returned by input-token |
| tx_valid | output | 1 | Outbound token available |
| tx_token | output | 9 | Outbound token, bit 8 is the control flag |
| tx_ready | input | 1 | Link accepts the outbound token |
| rx_valid | input | 1 | Inbound token offered |
| rx_token | input | 9 | Inbound token, bit 8 is the control flag |
| rx_ready | output | 1 | Inbound queue has room |

## Verification
Several words with distinct byte patterns are sent out and then looped back in. A byte-order or lane-swap fault shows up in the token sequence and again in the reassembled word. Both queues are driven to their limits: the outbound side is filled until a single extra token stalls, and the inbound side is filled until `rx_ready` drops. These cases separate a correct room or data count from an off-by-one and show that a stalled word is never split. A control token placed second in the inbound queue separates refusal without consumption from partial consumption. A cycle that completes a transfer in both directions at once, with a stable token held against backpressure, covers the link handshakes.

// File: rtl/chan_pkg.sv
package chan_pkg;
    localparam int BYTE_W    = 8;
    localparam int TOK_W     = BYTE_W + 1;
    localparam int WORD_TOKS = 4;
    localparam int WORD_W    = BYTE_W * WORD_TOKS;

    typedef logic [TOK_W-1:0] token_t;

    typedef enum logic [1:0] {
        OP_OUT_WORD = 2'd0,
        OP_OUT_TOK  = 2'd1,
        OP_IN_WORD  = 2'd2,
        OP_IN_TOK   = 2'd3
    } chan_op_e;
endpackage

// File: rtl/token_fifo.sv
module token_fifo
    import chan_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PORTS = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(PORTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NW-1:0]        wr_n,
    input  token_t [PORTS-1:0]   wr_tok,
    input  logic [NW-1:0]        rd_n,
    output logic [CW-1:0]        count,
    output token_t [PORTS-1:0]   peek
);
    // DEPTH must be a power of two so the pointers wrap naturally.
    typedef struct packed {
        token_t [DEPTH-1:0] mem;
        logic [PW-1:0]      wp;
        logic [PW-1:0]      rp;
        logic [CW-1:0]      cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < PORTS; i++) begin
            if (NW'(i) < wr_n) begin
                st_d.mem[PW'(st_q.wp + PW'(i))] = wr_tok[i];
            end
        end
        st_d.wp  = PW'(st_q.wp + PW'(wr_n));
        st_d.rp  = PW'(st_q.rp + PW'(rd_n));
        st_d.cnt = CW'(st_q.cnt + CW'(wr_n) - CW'(rd_n));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    for (genvar g = 0; g < PORTS; g++) begin : g_peek
        assign peek[g] = st_q.mem[PW'(st_q.rp + PW'(g))];
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(st_q.cnt + CW'(wr_n)) - CW'(rd_n) <= CW'(DEPTH));
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(rd_n) <= st_q.cnt);
endmodule

// File: rtl/chan_req_ctrl.sv
module chan_req_ctrl
    import chan_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(WORD_TOKS + 1)
) (
    input  logic                   req_valid,
    input  chan_op_e               req_op,
    input  logic [WORD_W-1:0]      req_wdata,
    input  logic                   req_ctrl,
    input  logic [CW-1:0]          ob_cnt,
    input  logic [CW-1:0]          ib_cnt,
    input  token_t [WORD_TOKS-1:0] ib_peek,
    output logic [NW-1:0]          ob_wr_n,
    output token_t [WORD_TOKS-1:0] ob_wr_tok,
    output logic [NW-1:0]          ib_rd_n,
    output logic                   stall,
    output logic                   proto_err,
    output logic [WORD_W-1:0]      rsp_data,
    output logic                   rsp_ctrl
);
    logic [CW-1:0] ob_free;
    logic          ctrl_hit;
    logic          serve;

    always_comb begin
        ob_free   = CW'(DEPTH) - ob_cnt;
        ctrl_hit  = 1'b0;
        for (int i = 0; i < WORD_TOKS; i++) ctrl_hit = ctrl_hit | ib_peek[i][TOK_W-1];
        serve     = 1'b0;
        proto_err = 1'b0;
        ob_wr_n   = '0;
        ob_wr_tok = '0;
        ib_rd_n   = '0;
        rsp_data  = '0;
        rsp_ctrl  = 1'b0;
        unique case (req_op)
            OP_OUT_WORD: begin
                serve = ob_free >= CW'(WORD_TOKS);
                for (int i = 0; i < WORD_TOKS; i++)
                    ob_wr_tok[i] = {1'b0, req_wdata[(WORD_TOKS-1-i)*BYTE_W +: BYTE_W]};
                if (req_valid && serve) ob_wr_n = NW'(WORD_TOKS);
            end
            OP_OUT_TOK: begin
                serve        = ob_free != '0;
                ob_wr_tok[0] = {req_ctrl, req_wdata[BYTE_W-1:0]};
                if (req_valid && serve) ob_wr_n = NW'(1);
            end
            OP_IN_WORD: begin
                for (int i = 0; i < WORD_TOKS; i++)
                    rsp_data[(WORD_TOKS-1-i)*BYTE_W +: BYTE_W] = ib_peek[i][BYTE_W-1:0];
                if (ib_cnt >= CW'(WORD_TOKS)) begin
                    proto_err = req_valid && ctrl_hit;
                    serve     = !ctrl_hit;
                end
                if (req_valid && serve) ib_rd_n = NW'(WORD_TOKS);
            end
            default: begin
                serve                  = ib_cnt != '0;
                rsp_data[BYTE_W-1:0]   = ib_peek[0][BYTE_W-1:0];
                rsp_ctrl               = ib_peek[0][TOK_W-1];
                if (req_valid && serve) ib_rd_n = NW'(1);
            end
        endcase
        stall = req_valid && !serve && !proto_err;
    end
endmodule

// File: rtl/chan_end.sv
module chan_end
    import chan_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [31:0] req_wdata,
    input  logic        req_ctrl,
    output logic        stall,
    output logic        proto_err,
    output logic [31:0] rsp_data,
    output logic        rsp_ctrl,
    output logic        tx_valid,
    output logic [8:0]  tx_token,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [8:0]  rx_token,
    output logic        rx_ready
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int NW = $clog2(WORD_TOKS + 1);

    logic [CW-1:0]          ob_cnt, ib_cnt;
    logic [NW-1:0]          ob_wr_n, ob_rd_n, ib_wr_n, ib_rd_n;
    token_t [WORD_TOKS-1:0] ob_wr_tok, ob_peek, ib_wr_tok, ib_peek;

    chan_req_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .req_valid (req_valid),
        .req_op    (chan_op_e'(req_op)),
        .req_wdata (req_wdata),
        .req_ctrl  (req_ctrl),
        .ob_cnt    (ob_cnt),
        .ib_cnt    (ib_cnt),
        .ib_peek   (ib_peek),
        .ob_wr_n   (ob_wr_n),
        .ob_wr_tok (ob_wr_tok),
        .ib_rd_n   (ib_rd_n),
        .stall     (stall),
        .proto_err (proto_err),
        .rsp_data  (rsp_data),
        .rsp_ctrl  (rsp_ctrl)
    );

    token_fifo #(.DEPTH(DEPTH), .PORTS(WORD_TOKS)) u_ob (
        .clk (clk), .rst_n (rst_n),
        .wr_n (ob_wr_n), .wr_tok (ob_wr_tok),
        .rd_n (ob_rd_n), .count (ob_cnt), .peek (ob_peek)
    );

    token_fifo #(.DEPTH(DEPTH), .PORTS(WORD_TOKS)) u_ib (
        .clk (clk), .rst_n (rst_n),
        .wr_n (ib_wr_n), .wr_tok (ib_wr_tok),
        .rd_n (ib_rd_n), .count (ib_cnt), .peek (ib_peek)
    );

    // Link side: one token per cycle in each direction.
    always_comb begin
        tx_valid  = ob_cnt != '0;
        tx_token  = ob_peek[0];
        ob_rd_n   = NW'(tx_valid && tx_ready);
        rx_ready  = ib_cnt < CW'(DEPTH);
        ib_wr_tok = '0;
        ib_wr_tok[0] = rx_token;
        ib_wr_n   = NW'(rx_valid && rx_ready);
    end

    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_token));
    p_stall_noadd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall && !req_op[1] |=> ob_cnt <= $past(ob_cnt));
    p_err_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> ib_cnt >= $past(ib_cnt));
    p_full_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ib_cnt == CW'(DEPTH) |-> !rx_ready);
endmodule

// File: tb/test_chan_end.sv
`timescale 1ns/1ps
module test_chan_end;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_wdata = '0;
    logic        req_ctrl = 1'b0;
    logic        stall, proto_err, rsp_ctrl, tx_valid, rx_ready;
    logic [31:0] rsp_data;
    logic [8:0]  tx_token;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [8:0]  rx_token = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam logic [31:0] VEC [4] = '{32'h0102_0304, 32'hA55A_F00F, 32'hFF00_7E81, 32'h8C3D_2B19};

    always #5 clk = ~clk;

    chan_end i_chan_end (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_op (req_op), .req_wdata (req_wdata), .req_ctrl (req_ctrl),
        .stall (stall), .proto_err (proto_err), .rsp_data (rsp_data), .rsp_ctrl (rsp_ctrl),
        .tx_valid (tx_valid), .tx_token (tx_token), .tx_ready (tx_ready),
        .rx_valid (rx_valid), .rx_token (rx_token), .rx_ready (rx_ready)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] op, input logic [31:0] d, input logic c,
                          output logic [31:0] rd, output logic rc, output logic er, output int waits);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_wdata = d; req_ctrl = c;
        #1;
        waits = 0;
        while (stall) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = rsp_data; rc = rsp_ctrl; er = proto_err;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic pop_tx(output logic v, output logic [8:0] t);
        @(negedge clk);
        tx_ready = 1'b1;
        #1;
        v = tx_valid; t = tx_token;
        @(posedge clk); #1;
        tx_ready = 1'b0;
    endtask

    task automatic push_rx(input logic [8:0] t, output logic rdy);
        @(negedge clk);
        rx_valid = 1'b1; rx_token = t;
        #1;
        rdy = rx_ready;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic rc, er, v, rdy;
        logic [8:0] t;
        int w;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 stall", stall, 0);
        chk("R1 proto_err", proto_err, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 rx_ready", rx_ready, 1);

        // R2 / R5 table walk: send word out, loop tokens back in, read word
        for (int k = 0; k < 4; k++) begin
            do_req(2'd0, VEC[k], 1'b0, rd, rc, er, w);
            chk("R2 no stall", w, 0);
            for (int b = 0; b < 4; b++) begin
                pop_tx(v, t);
                chk("R2 token", {v, t}, {1'b1, 1'b0, VEC[k][31-8*b -: 8]});
                push_rx(t, rdy);
            end
            do_req(2'd2, 32'h0, 1'b0, rd, rc, er, w);
            chk("R5 word", {er, rd}, {1'b0, VEC[k]});
        end

        // R3 single control token
        do_req(2'd1, 32'hDEAD_BE5A, 1'b1, rd, rc, er, w);
        pop_tx(v, t);
        chk("R3 ctrl token", {v, t}, {1'b1, 9'h15A});

        // R4 full outbound queue stalls an extra token, no split
        do_req(2'd0, 32'h1122_3344, 1'b0, rd, rc, er, w);
        do_req(2'd0, 32'h5566_7788, 1'b0, rd, rc, er, w);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_wdata = 32'h77; req_ctrl = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R4 stall held", stall, 1);
            @(negedge clk);
        end
        tx_ready = 1'b1;
        #1 chk("R4 head", tx_token, 9'h011);
        @(posedge clk); #1;
        tx_ready = 1'b0;
        chk("R4 resumes", stall, 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        for (int b = 0; b < 8; b++) begin
            logic [8:0] e;
            e = (b < 3) ? {1'b0, 8'h22 + 8'(8'h11 * b)} :
                (b < 7) ? {1'b0, 8'h55 + 8'(8'h11 * (b - 3))} : 9'h077;
            pop_tx(v, t);
            chk("R4 order", {v, t}, {1'b1, e});
        end
        @(negedge clk); #1;
        chk("R4 drained", tx_valid, 0);

        // R6 input token on empty queue stalls, then returns control token
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3;
        #1 chk("R6 stall empty", stall, 1);
        @(negedge clk);
        #1 chk("R6 stall empty 2", stall, 1);
        rx_valid = 1'b1; rx_token = 9'h1C3;
        @(posedge clk); #1;
        rx_valid = 1'b0;
        chk("R6 served", {stall, rsp_ctrl, rsp_data[7:0]}, {1'b0, 1'b1, 8'hC3});
        @(posedge clk); #1;
        req_valid = 1'b0;

        // R5 input word waits for the fourth token
        push_rx(9'h0AB, rdy);
        push_rx(9'h0CD, rdy);
        push_rx(9'h0EF, rdy);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd2;
        #1 chk("R5 stall at 3", stall, 1);
        rx_valid = 1'b1; rx_token = 9'h012;
        @(posedge clk); #1;
        rx_valid = 1'b0;
        chk("R5 complete", {stall, rsp_data}, {1'b0, 32'hABCD_EF12});
        @(posedge clk); #1;
        req_valid = 1'b0;

        // R7 control token inside a word: error, nothing consumed
        push_rx(9'h011, rdy);
        push_rx(9'h102, rdy);
        push_rx(9'h033, rdy);
        push_rx(9'h044, rdy);
        do_req(2'd2, 32'h0, 1'b0, rd, rc, er, w);
        chk("R7 err", {er, 8'(w)}, {1'b1, 8'd0});
        do_req(2'd3, 32'h0, 1'b0, rd, rc, er, w);
        chk("R7 first kept", {rc, rd[7:0]}, {1'b0, 8'h11});
        do_req(2'd3, 32'h0, 1'b0, rd, rc, er, w);
        chk("R7 ctrl next", {rc, rd[7:0]}, {1'b1, 8'h02});
        do_req(2'd3, 32'h0, 1'b0, rd, rc, er, w);
        do_req(2'd3, 32'h0, 1'b0, rd, rc, er, w);
        chk("R7 last", {rc, rd[7:0]}, {1'b0, 8'h44});

        // R8 inbound full blocks the ninth token
        for (int i = 0; i < 8; i++) push_rx(9'(8'h60 + 8'(i)), rdy);
        push_rx(9'h0FF, rdy);
        chk("R8 rx_ready low", rdy, 0);
        for (int i = 0; i < 8; i++) begin
            do_req(2'd3, 32'h0, 1'b0, rd, rc, er, w);
            chk("R8 kept", {rc, rd[7:0]}, {1'b0, 8'h60 + 8'(i)});
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3;
        #1 chk("R8 ninth dropped", stall, 1);
        @(posedge clk); #1;
        req_valid = 1'b0;

        // R10 held token under backpressure, then R9 both directions at once
        do_req(2'd1, 32'h3C, 1'b1, rd, rc, er, w);
        @(negedge clk); #1;
        t = tx_token;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R10 stable", {tx_valid, tx_token}, {1'b1, t});
        end
        @(negedge clk);
        tx_ready = 1'b1; rx_valid = 1'b1; rx_token = 9'h0A7;
        #1 chk("R9 both ready", {tx_valid, rx_ready, tx_token}, {1'b1, 1'b1, 9'h13C});
        @(posedge clk); #1;
        tx_ready = 1'b0; rx_valid = 1'b0;
        chk("R9 tx done", tx_valid, 0);
        do_req(2'd3, 32'h0, 1'b0, rd, rc, er, w);
        chk("R9 rx done", {rc, rd[7:0], 8'(w)}, {1'b0, 8'hA7, 8'd0});

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule